// File: doc/BRIEF.md
# NAND Page Transfer Sequencer

This block runs whole-page read and program operations on an 8-bit asynchronous NAND flash device. A host presents a column and row address and a direction on a valid/ready request port. The block then walks the device through its command, address, data, busy and status phases on one shared 8-bit bus. It marks each byte as a command or an address only by raising the command-qualifier or address-qualifier line while that byte is strobed.

Write bytes come in on a valid/ready stream and read bytes go out on another. The write and read strobes are built from parameterised low and high times counted in clock cycles. The block waits on the device's ready/busy line before it starts any new phase. A program operation ends with a status read, and bit 0 of that status byte is returned as the pass/fail flag. Each operation finishes with a one-cycle done pulse.

Top module: `nand_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), both qualifiers, write protect (`nf_wp_n`) and bus drive are low, `rd_valid` and `done` are low, and `req_ready` is high whenever `nf_rb` is high.
- R2: A read sends command byte 0x00 with `nf_cle` high. It then sends five address bytes with `nf_ale` high, in the order column low, column high, row low, row middle, row high. It sends command 0x30, waits for the device, and then reads exactly `PAGE_BYTES` bytes with read-strobe pulses.
- R3: A program sends command 0x80 and the same five address bytes, then `PAGE_BYTES` data bytes, then command 0x10. It waits for the device, sends command 0x70 and reads one status byte. `done_fail` equals bit 0 of that status byte and is 0 for reads.
- R4: `nf_cle` is high only while a command byte is strobed and `nf_ale` only while an address byte is strobed; the two are never high together.
- R5: Every write or read strobe stays low for exactly `T_LOW` cycles, consecutive strobes are separated by at least `T_HIGH` high cycles, and the two strobes are never low together.
- R6: At least `T_GAP`+1 idle cycles separate the last cycle with `nf_ale` high from the first write-data strobe.
- R7: No strobe falls and no request is accepted while `nf_rb` is low. After command 0x30 or 0x10 the block waits `T_WB` cycles and then until `nf_rb` is high.
- R8: `nf_wp_n` is high from the cycle after a program request is accepted through its final status byte, and low during reads and when idle.
- R9: `nf_ce_n` stays low from the cycle after acceptance through the final byte. It goes high together with a one-cycle `done` pulse, and no strobe occurs while it is high.
- R10: Read bytes arrive in device order. `rd_valid`/`rd_data` hold until `rd_ready`, and no further read strobe starts while a byte is unconsumed.
- R11: A data write strobe starts only on a `wr_valid`/`wr_ready` handshake. The bus byte, `nf_cle` and `nf_ale` stay stable while the write strobe is low, and input stalls only delay the transfer.
- R12: `nf_io_oe` is high during every write strobe and low during every read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = page program, 0 = page read |
| req_col | input | 16 | Column address |
| req_row | input | 24 | Row (page) address |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Program data taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Read data consumed |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_fail | output | 1 | Program status bit 0, valid with done |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command qualifier |
| nf_ale | output | 1 | Address qualifier |
| nf_we_n | output | 1 | Write strobe, device latches on rising edge |
| nf_re_n | output | 1 | Read strobe, device drives on falling edge |
| nf_wp_n | output | 1 | Write protect, high permits program |
| nf_io_out | output | 8 | Bus byte driven to device |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_io_in | input | 8 | Bus byte from device |
| nf_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
On every cycle, the assertions check the per-strobe protocol rules. These are qualifier exclusivity, strobe low width and exclusivity, chip enable and direction around each strobe, and write protect on data strobes. They also check the address-to-data gap, the busy line at each strobe, qualifier and bus stability during a write strobe, and holding of stalled read data. Only the bench scenarios can show the content and order of whole operations. That covers the exact byte sequences of reads and programs, the page data delivered against the device's pattern, the pass/fail status, and that requests wait while the device is held busy.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int ADDR_CYC = 5;
  localparam logic [7:0] OP_RD_SETUP = 8'h00;
  localparam logic [7:0] OP_RD_GO    = 8'h30;
  localparam logic [7:0] OP_PG_SETUP = 8'h80;
  localparam logic [7:0] OP_PG_GO    = 8'h10;
  localparam logic [7:0] OP_STATUS   = 8'h70;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_GAP, S_WDATA, S_CMD2,
    S_BUSY, S_RDATA, S_STCMD, S_STGAP, S_STRD, S_DONE
  } seq_state_t;

  // Address cycles: column low/high, then row low/middle/high.
  function automatic logic [7:0] addr_byte(input logic [15:0] col,
                                           input logic [23:0] row,
                                           input logic [2:0]  idx);
    case (idx)
      3'd0:    return col[7:0];
      3'd1:    return col[15:8];
      3'd2:    return row[7:0];
      3'd3:    return row[15:8];
      default: return row[23:16];
    endcase
  endfunction

  function automatic logic [7:0] setup_cmd(input logic wr);
    return wr ? OP_PG_SETUP : OP_RD_SETUP;
  endfunction

  function automatic logic [7:0] go_cmd(input logic wr);
    return wr ? OP_PG_GO : OP_RD_GO;
  endfunction
endpackage

// File: rtl/nand_strobe.sv
module nand_strobe #(
  parameter int T_LOW  = 2,
  parameter int T_HIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic active,
  output logic low,
  output logic rise_evt,
  output logic last_evt
);
  localparam int CMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int CW   = $clog2(CMAX + 1);

  logic          in_low;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      in_low <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        in_low <= 1'b1;
        cnt    <= CW'(T_LOW - 1);
      end
    end else if (in_low) begin
      if (cnt == '0) begin
        in_low <= 1'b0;
        cnt    <= CW'(T_HIGH - 1);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign low      = active && in_low;
  assign rise_evt = active && in_low && (cnt == '0);
  assign last_evt = active && !in_low && (cnt == '0);
endmodule

// File: rtl/nand_tick.sv
module nand_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= len;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2,
  parameter int T_GAP      = 2,
  parameter int T_WB       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_col,
  input  logic [23:0] req_row,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic        done,
  output logic        done_fail,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic        nf_wp_n,
  output logic [7:0]  nf_io_out,
  output logic        nf_io_oe,
  input  logic [7:0]  nf_io_in,
  input  logic        nf_rb
);
  localparam int IMAX = (PAGE_BYTES > ADDR_CYC) ? PAGE_BYTES : ADDR_CYC;
  localparam int IW   = $clog2(IMAX);
  localparam int TMAX = (T_GAP > T_WB) ? T_GAP : T_WB;
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_t    state;
  logic          op_wr;
  logic [15:0]   col_q;
  logic [23:0]   row_q;
  logic [IW-1:0] idx;
  logic [7:0]    wbyte;
  logic [7:0]    rd_q;
  logic          rd_v;
  logic          stat_bit;

  // Named internal events
  logic          sg_go, sg_active, sg_low, sg_rise, sg_last;
  logic          tk_load, tk_zero;
  logic [TW-1:0] tk_len;
  logic          dir_out, byte_state, addr_done, page_done;

  nand_strobe #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(sg_go), .active(sg_active),
    .low(sg_low), .rise_evt(sg_rise), .last_evt(sg_last)
  );

  nand_tick #(.W(TW)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(tk_load), .len(tk_len), .zero(tk_zero)
  );

  assign addr_done  = (idx == IW'(ADDR_CYC - 1));
  assign page_done  = (idx == IW'(PAGE_BYTES - 1));
  assign byte_state = (state == S_CMD1) || (state == S_ADDR) || (state == S_CMD2) ||
                      (state == S_STCMD) || (state == S_STRD);
  assign dir_out    = (state == S_CMD1) || (state == S_ADDR) || (state == S_WDATA) ||
                      (state == S_CMD2) || (state == S_STCMD);

  always_comb begin
    sg_go   = 1'b0;
    tk_load = 1'b0;
    tk_len  = '0;
    if (byte_state)                sg_go = !sg_active;
    else if (state == S_WDATA)     sg_go = !sg_active && wr_valid;
    else if (state == S_RDATA)     sg_go = !sg_active && !rd_v;
    if ((state == S_ADDR && sg_last && addr_done && op_wr) ||
        (state == S_STCMD && sg_last)) begin
      tk_load = 1'b1;
      tk_len  = TW'(T_GAP - 1);
    end else if (state == S_CMD2 && sg_last) begin
      tk_load = 1'b1;
      tk_len  = TW'(T_WB - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_wr    <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
      idx      <= '0;
      wbyte    <= '0;
      rd_q     <= '0;
      rd_v     <= 1'b0;
      stat_bit <= 1'b0;
    end else begin
      if (rd_v && rd_ready) rd_v <= 1'b0;
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          op_wr <= req_write;
          col_q <= req_col;
          row_q <= req_row;
          idx   <= '0;
          state <= S_CMD1;
        end
        S_CMD1: if (sg_last) state <= S_ADDR;
        S_ADDR: if (sg_last) begin
          if (addr_done) begin
            idx   <= '0;
            state <= op_wr ? S_GAP : S_CMD2;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_GAP: if (tk_zero) state <= S_WDATA;
        S_WDATA: begin
          if (sg_go) wbyte <= wr_data;
          if (sg_last) begin
            if (page_done) begin
              idx   <= '0;
              state <= S_CMD2;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_CMD2: if (sg_last) state <= S_BUSY;
        S_BUSY: if (tk_zero && nf_rb) state <= op_wr ? S_STCMD : S_RDATA;
        S_RDATA: begin
          if (sg_rise) begin
            rd_q <= nf_io_in;
            rd_v <= 1'b1;
          end
          if (sg_last) begin
            if (page_done) begin
              idx   <= '0;
              state <= S_DONE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_STCMD: if (sg_last) state <= S_STGAP;
        S_STGAP: if (tk_zero) state <= S_STRD;
        S_STRD: begin
          if (sg_rise) stat_bit <= nf_io_in[0];
          if (sg_last) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_CMD1:  nf_io_out = setup_cmd(op_wr);
      S_ADDR:  nf_io_out = addr_byte(col_q, row_q, idx[2:0]);
      S_WDATA: nf_io_out = wbyte;
      S_CMD2:  nf_io_out = go_cmd(op_wr);
      S_STCMD: nf_io_out = OP_STATUS;
      default: nf_io_out = '0;
    endcase
  end

  assign req_ready = (state == S_IDLE) && nf_rb;
  assign wr_ready  = (state == S_WDATA) && !sg_active;
  assign rd_data   = rd_q;
  assign rd_valid  = rd_v;
  assign done      = (state == S_DONE);
  assign done_fail = done && op_wr && stat_bit;
  assign nf_ce_n   = (state == S_IDLE) || (state == S_DONE);
  assign nf_cle    = (state == S_CMD1) || (state == S_CMD2) || (state == S_STCMD);
  assign nf_ale    = (state == S_ADDR);
  assign nf_we_n   = !(sg_low && dir_out);
  assign nf_re_n   = !(sg_low && !dir_out);
  assign nf_wp_n   = op_wr && !nf_ce_n;
  assign nf_io_oe  = dir_out;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int T_LOW = 2,
  parameter int T_GAP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_wp_n,
  input logic       nf_io_oe,
  input logic [7:0] nf_io_out,
  input logic       nf_rb,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done
);
  int low_run;
  int since_ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= 0;
      since_ale <= 0;
    end else begin
      low_run   <= (!nf_we_n || !nf_re_n) ? low_run + 1 : 0;
      since_ale <= nf_ale ? 0 : ((since_ale < 1000) ? since_ale + 1 : since_ale);
    end
  end

  AST_QUAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n)); // R5
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(nf_we_n && nf_re_n) |-> low_run == T_LOW); // R5
  AST_ALE_GAP: assert property (@(posedge clk) disable iff (!rst_n) ($fell(nf_we_n) && !nf_cle && !nf_ale) |-> since_ale > T_GAP); // R6
  AST_RB_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(nf_we_n) || $fell(nf_re_n)) |-> nf_rb); // R7
  AST_WP_DATA: assert property (@(posedge clk) disable iff (!rst_n) (!nf_we_n && !nf_cle && !nf_ale) |-> nf_wp_n); // R8
  AST_CE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R9
  AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(nf_ce_n) |-> done); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10
  AST_WE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_io_out))); // R11
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> nf_io_oe); // R12
  AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |-> !nf_io_oe); // R12
endmodule

bind nand_seq nand_seq_chk #(.T_LOW(T_LOW), .T_GAP(T_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n), .nf_io_oe(nf_io_oe),
  .nf_io_out(nf_io_out), .nf_rb(nf_rb), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .done(done)
);

// File: tb/nand_seq_tb.sv
module nand_seq_tb_top;
  localparam int PB = 16;
  localparam int TL = 2;
  localparam int TH = 2;
  localparam int TG = 2;
  localparam int TWB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_col = '0;
  logic [23:0] req_row = '0;
  logic        req_ready;
  logic [7:0]  wr_data;
  logic        wr_valid, wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid, rd_ready;
  logic        done, done_fail;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_io_oe, nf_rb;
  logic [7:0]  nf_io_out, nf_io_in;

  nand_seq #(.PAGE_BYTES(PB), .T_LOW(TL), .T_HIGH(TH), .T_GAP(TG), .T_WB(TWB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_col(req_col), .req_row(req_row),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .done_fail(done_fail), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb(nf_rb)
  );

  function automatic logic [7:0] rd_pat(input int i);
    return 8'((i * 29 + 11) & 255);
  endfunction
  function automatic logic [7:0] wr_pat(input int i, input int seed);
    return 8'((i * 13 + seed) & 255);
  endfunction

  // Stimulus controls, written only by the main initial block
  logic       wr_en = 1'b0, wr_stall = 1'b0, rd_throttle = 1'b0, force_busy = 1'b0;
  int         wr_seed = 0, wr_base = 0;
  logic [7:0] dev_status = 8'hE0;

  // Monitor / device model state, written only by the monitor
  logic [9:0] log_q[$];
  logic [7:0] rdq[$];
  int  acc_cnt = 0, done_cnt = 0, wr_taken = 0;
  logic fail_cap = 1'b0;
  int  dev_cnt = 0, dev_ptr = 0;
  logic stat_mode = 1'b0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  int  low_run = 0, high_run = 0, since_ale = 0;
  logic high_ok = 1'b0, in_op = 1'b0, op_wr = 1'b0;
  logic hold_pend = 1'b0;
  logic [7:0] hold_data = '0;
  int  m_tests = 0, m_fail = 0;
  int  t_tests = 0, t_fail = 0;

  assign nf_rb    = !(dev_cnt >= 1 && dev_cnt <= 20) && !force_busy;
  assign nf_io_in = stat_mode ? dev_status : rd_pat(dev_ptr);

  task automatic chk_m(input bit ok, input string tag, input string what, input int act, input int exp);
    m_tests++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    t_tests++;
    if (!ok) begin
      t_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Input drivers away from the active edge
  int ncyc = 0;
  always @(negedge clk) begin
    ncyc++;
    rd_ready = !rd_throttle || (ncyc % 3 == 0);
    wr_valid = wr_en && ((wr_taken - wr_base) < PB) && (!wr_stall || (ncyc % 2 == 0));
    wr_data  = wr_pat(wr_taken - wr_base, wr_seed);
  end

  // Cycle-by-cycle reference model and device model
  always @(posedge clk) begin
    if (rst_n) begin
      // chip enable / write protect model (R8, R9)
      chk_m(nf_ce_n == !(in_op && !done), "R9", "ce_n vs model", int'(nf_ce_n), int'(!(in_op && !done)));
      chk_m(nf_wp_n == (in_op && !done && op_wr), "R8", "wp_n vs model", int'(nf_wp_n), int'(in_op && !done && op_wr));
      if (hold_pend)
        chk_m(rd_valid && rd_data == hold_data, "R10", "stalled read byte held", int'(rd_data), int'(hold_data));
      hold_pend = rd_valid && !rd_ready;
      hold_data = rd_data;

      if (req_valid && req_ready) begin
        acc_cnt++;
        in_op = 1'b1;
        op_wr = req_write;
      end
      if (done) begin
        done_cnt++;
        fail_cap = done_fail;
        in_op = 1'b0;
      end
      if (wr_valid && wr_ready) wr_taken++;
      if (rd_valid && rd_ready) rdq.push_back(rd_data);

      // strobe falls
      if ((prev_we && !nf_we_n) || (prev_re && !nf_re_n)) begin
        chk_m(!nf_ce_n, "R9", "ce low at strobe", int'(nf_ce_n), 0);
        chk_m(nf_rb, "R7", "ready at strobe", int'(nf_rb), 1);
        chk_m(!(nf_cle && nf_ale), "R4", "qualifiers exclusive", int'({nf_cle, nf_ale}), 0);
        chk_m(!(!nf_we_n && !nf_re_n), "R5", "one strobe at a time", 0, 1);
        if (high_ok) chk_m(high_run >= TH, "R5", "strobe high time", high_run, TH);
        if (!nf_we_n) chk_m(nf_io_oe, "R12", "oe during write strobe", int'(nf_io_oe), 1);
        else          chk_m(!nf_io_oe, "R12", "oe during read strobe", int'(nf_io_oe), 0);
        if (!nf_we_n && !nf_cle && !nf_ale)
          chk_m(since_ale >= TG + 1, "R6", "gap after address", since_ale, TG + 1);
        high_run = 0;
        high_ok  = 1'b1;
      end
      // strobe rises
      if ((!prev_we && nf_we_n) || (!prev_re && nf_re_n)) begin
        chk_m(low_run == TL, "R5", "strobe low time", low_run, TL);
        low_run = 0;
      end
      if (!prev_we && nf_we_n && !nf_ce_n) begin
        log_q.push_back({nf_cle, nf_ale, nf_io_out});
        if (nf_cle && (nf_io_out == 8'h30 || nf_io_out == 8'h10)) dev_cnt = 22;
        if (nf_cle && nf_io_out == 8'h70) stat_mode = 1'b1;
        if (nf_cle && nf_io_out == 8'h00) begin
          stat_mode = 1'b0;
          dev_ptr = 0;
        end
      end
      if (!prev_re && nf_re_n && !nf_ce_n && !stat_mode) dev_ptr++;

      if (!nf_we_n || !nf_re_n) low_run++;
      else if (!nf_ce_n) high_run++;
      if (nf_ce_n) high_ok = 1'b0;
      since_ale = nf_ale ? 0 : since_ale + 1;
      if (dev_cnt > 0) dev_cnt--;
      prev_we = nf_we_n;
      prev_re = nf_re_n;
    end
  end

  task automatic run_op(input bit wr, input logic [15:0] col, input logic [23:0] row,
                        input bit st_fail, input bit throttle, input int seed);
    int log0, rd0, a0, d0;
    logic [9:0] exp_q[$];
    int mism;
    log0 = log_q.size();
    rd0  = rdq.size();
    a0   = acc_cnt;
    d0   = done_cnt;
    @(negedge clk);
    dev_status  = 8'hE0 | 8'(st_fail);
    wr_seed     = seed;
    wr_base     = wr_taken;
    wr_en       = wr;
    wr_stall    = throttle;
    rd_throttle = throttle;
    req_write = wr; req_col = col; req_row = row; req_valid = 1'b1;
    while (acc_cnt == a0) @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    wr_en = 1'b0; wr_stall = 1'b0; rd_throttle = 1'b0;

    exp_q.push_back({2'b10, wr ? 8'h80 : 8'h00});
    exp_q.push_back({2'b01, col[7:0]});
    exp_q.push_back({2'b01, col[15:8]});
    exp_q.push_back({2'b01, row[7:0]});
    exp_q.push_back({2'b01, row[15:8]});
    exp_q.push_back({2'b01, row[23:16]});
    if (wr) for (int i = 0; i < PB; i++) exp_q.push_back({2'b00, wr_pat(i, seed)});
    exp_q.push_back({2'b10, wr ? 8'h10 : 8'h30});
    if (wr) exp_q.push_back({2'b10, 8'h70});

    chk(log_q.size() - log0 == exp_q.size(), wr ? "R3" : "R2", "bytes written to device",
        log_q.size() - log0, exp_q.size());
    mism = 0;
    for (int i = 0; i < exp_q.size() && (log0 + i) < log_q.size(); i++) begin
      if (log_q[log0 + i] != exp_q[i] && mism == 0) begin
        chk(1'b0, wr ? "R3" : "R2", $sformatf("byte %0d {cle,ale,data}", i),
            int'(log_q[log0 + i]), int'(exp_q[i]));
        mism = 1;
      end
    end
    if (mism == 0) chk(1'b1, "R4", "qualified sequence", 0, 0);
    if (wr) begin
      chk(1'b1, "R11", "data stream", 0, 0);
      chk(fail_cap == st_fail, "R3", "status pass/fail", int'(fail_cap), int'(st_fail));
    end else begin
      chk(rdq.size() - rd0 == PB, "R10", "read bytes delivered", rdq.size() - rd0, PB);
      mism = 0;
      for (int i = 0; i < PB && (rd0 + i) < rdq.size(); i++)
        if (rdq[rd0 + i] != rd_pat(i) && mism == 0) begin
          chk(1'b0, "R10", $sformatf("read byte %0d", i), int'(rdq[rd0 + i]), int'(rd_pat(i)));
          mism = 1;
        end
      if (mism == 0) chk(1'b1, "R2", "page data order", 0, 0);
      chk(fail_cap == 1'b0, "R3", "read reports pass", int'(fail_cap), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nf_ce_n == 1'b1, "R1", "ce_n after reset", int'(nf_ce_n), 1);
    chk(nf_we_n && nf_re_n, "R1", "strobes after reset", int'({nf_we_n, nf_re_n}), 3);
    chk(!nf_cle && !nf_ale, "R1", "qualifiers after reset", int'({nf_cle, nf_ale}), 0);
    chk(!nf_wp_n && !nf_io_oe, "R1", "wp/oe after reset", int'({nf_wp_n, nf_io_oe}), 0);
    chk(!rd_valid && !done, "R1", "rd_valid/done after reset", int'({rd_valid, done}), 0);
    chk(req_ready, "R1", "req_ready after reset", int'(req_ready), 1);

    run_op(1'b0, 16'h1234, 24'hABCDEF, 1'b0, 1'b0, 0);
    run_op(1'b0, 16'h0000, 24'h000001, 1'b0, 1'b1, 0);
    run_op(1'b1, 16'h0800, 24'h123456, 1'b0, 1'b0, 100);
    run_op(1'b1, 16'h00FF, 24'h7F0102, 1'b1, 1'b1, 7);

    // R7: request held off while the device reports busy
    @(negedge clk);
    force_busy = 1'b1;
    req_write = 1'b0; req_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0 || i == 19) begin
        chk(!req_ready, "R7", "req_ready while busy", int'(req_ready), 0);
        chk(nf_ce_n, "R7", "no operation starts while busy", int'(nf_ce_n), 1);
      end
    end
    req_valid = 1'b0;
    force_busy = 1'b0;
    run_op(1'b0, 16'h4321, 24'h00FEDC, 1'b0, 1'b1, 0);

    $display("[TB] %0d tests run, %0d failed", t_tests + m_tests, t_fail + m_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", t_tests + m_tests + 1, t_fail + m_fail + 1);
    $finish;
  end
endmodule